// File: doc/BRIEF.md
# Stochastic Variable Node with Edge Memory

This block is one variable-node unit of a bit-serial stochastic LDPC decoder. Every sampling clock it takes one stochastic bit from the channel and one extrinsic bit from each of the parity-check nodes it listens to. From these it produces one stochastic output bit, which goes to the check node that is excluded from the inputs. When all inputs carry the same value, the node is regenerative: it emits that value and, if it has just entered agreement, pushes the value into a small shift-register edge memory. When the inputs disagree, the node is degenerative: it replays a bit taken from the edge memory at a random address supplied from outside. Replaying a stored bit keeps the stream switching and avoids lock-up.

Before decoding, an initialization phase fills the edge memory straight from the channel stochastic stream. During this phase the node output is held low so that nothing reaches the check nodes. The design is synchronous: the agreement indicator and the output are registered on the sampling clock, so an output bit appears one cycle after its inputs are sampled.

Top module: `sto_vnode`

## Requirements
- R1: After reset the output is 0 and every edge-memory entry is 0, so a degenerative read at any address returns 0.
- R2: When init_i is low and the channel bit and all extrinsic bits are 1, the output is 1 one clock later. When they are all 0, the output is 0 one clock later.
- R3: When init_i is low and the inputs are not all equal, the output one clock later is the edge-memory entry at index rd_addr_i, read before any update at that edge. Index 0 holds the newest bit and index DEPTH-1 the oldest.
- R4: On the clock edge at which the registered agreement indicator changes from 0 to 1, the common input value enters index 0, every entry moves up one index, and the entry at index DEPTH-1 is discarded.
- R5: While the indicator stays 1, nothing is stored. This covers staying in agreement and a direct switch between all-zeros and all-ones.
- R6: While init_i is high, chan_i is shifted into index 0 on every clock and the extrinsic inputs have no effect.
- R7: While init_i is high, the output one clock later is 0.
- R8: Initialization clears the agreement indicator, so the first agreeing input pattern after init_i falls is stored.
- R9: A degenerative cycle never changes the edge memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | High during edge-memory initialization |
| chan_i | input | 1 | Channel stochastic bit |
| ext_i | input | EXT_N | Extrinsic stochastic bits from the included check nodes |
| rd_addr_i | input | ADDR_W | Random edge-memory read address |
| out_o | output | 1 | Registered stochastic output bit |

## Verification
A wrong edge-memory entry stays hidden until a degenerative cycle addresses it. It then shows at out_o one clock later. For this reason the bench sweeps every address after each store and each initialization. A stuck or misclocked agreement indicator causes an extra or a missing shift. Every later degenerative read then shows this as a one-position offset in the stored pattern. An output that is not gated during initialization shows at out_o on the cycle after init_i rises.

// File: rtl/svn_pkg.sv
package svn_pkg;
   typedef enum logic [1:0] {
      VN_LOAD  = 2'd0,
      VN_AGREE = 2'd1,
      VN_SPLIT = 2'd2
   } vn_mode_e;

   function automatic vn_mode_e pick_mode(input logic loading, input logic agree);
      if (loading)    return VN_LOAD;
      else if (agree) return VN_AGREE;
      else            return VN_SPLIT;
   endfunction
endpackage

// File: rtl/vn_agree.sv
module vn_agree #(
   parameter int N = 3
) (
   input  logic [N-1:0] bits_i,
   output logic         all_one_o,
   output logic         all_zero_o
);
   logic [N:0] one_chain;
   logic [N:0] zero_chain;

   initial begin
      if (N < 2) $error("vn_agree: N must be at least 2");
   end

   assign one_chain[0]  = 1'b1;
   assign zero_chain[0] = 1'b1;

   for (genvar g = 0; g < N; g++) begin : g_chain
      assign one_chain[g+1]  = one_chain[g] & bits_i[g];
      assign zero_chain[g+1] = zero_chain[g] & ~bits_i[g];
   end

   assign all_one_o  = one_chain[N];
   assign all_zero_o = zero_chain[N];
endmodule

// File: rtl/vn_edge_mem.sv
module vn_edge_mem #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              din_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              dout_o
);
   localparam int LAST = DEPTH - 1;

   logic [DEPTH-1:0] cells;

   initial begin
      if (DEPTH < 2) $error("vn_edge_mem: DEPTH must be at least 2");
      if ((1 << ADDR_W) != DEPTH) $error("vn_edge_mem: DEPTH must equal 2**ADDR_W");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cells[0] <= 1'b0;
            else if (shift_i) cells[0] <= din_i;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cells[g] <= 1'b0;
            else if (shift_i) cells[g] <= cells[g-1];
         end
      end
   end

   assign dout_o = cells[addr_i];

   // R4 / R6: shift moves newest into index 0, rest move up
   a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (cells[0] == $past(din_i)) && (cells[LAST:1] == $past(cells[LAST-1:0])));

   // R9: no shift request leaves contents untouched
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(cells));
endmodule

// File: rtl/sto_vnode.sv
module sto_vnode
   import svn_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int EXT_N  = 2,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              chan_i,
   input  logic [EXT_N-1:0]  ext_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic              out_o
);
   localparam int NIN = EXT_N + 1;

   logic [NIN-1:0] in_bits;
   logic           all_one, all_zero, agree_now;
   logic           agree_q;
   logic           store;
   logic           mem_bit;
   logic           out_q;
   logic           out_d;
   vn_mode_e       mode;

   initial begin
      if (EXT_N < 1) $error("sto_vnode: EXT_N must be at least 1");
      if ((1 << ADDR_W) != DEPTH) $error("sto_vnode: DEPTH must equal 2**ADDR_W");
   end

   assign in_bits = {ext_i, chan_i};

   vn_agree #(.N(NIN)) u_agree (
      .bits_i     (in_bits),
      .all_one_o  (all_one),
      .all_zero_o (all_zero)
   );

   assign agree_now = all_one | all_zero;
   assign mode      = pick_mode(init_i, agree_now);
   assign store     = init_i | (agree_now & ~agree_q);

   vn_edge_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (store),
      .din_i   (chan_i),
      .addr_i  (rd_addr_i),
      .dout_o  (mem_bit)
   );

   always_comb begin
      unique case (mode)
         VN_LOAD:  out_d = 1'b0;
         VN_AGREE: out_d = chan_i;
         default:  out_d = mem_bit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         agree_q <= 1'b0;
         out_q   <= 1'b0;
      end else begin
         agree_q <= (mode == VN_AGREE);
         out_q   <= out_d;
      end
   end

   assign out_o = out_q;

   // R2: unanimous ones / zeros reach the output one cycle later
   a_r2_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && (&in_bits)) |=> out_o);
   a_r2_zeros: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !(|in_bits)) |=> !out_o);

   // R3: disagreement replays the addressed memory bit
   a_r3_replay: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && (|in_bits) && !(&in_bits)) |=> (out_o == $past(mem_bit)));

   // R7: output quiet during initialization
   a_r7_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> !out_o);

   // R8: initialization leaves the indicator clear
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> !agree_q);
endmodule

// File: tb/sto_vnode_bench.sv
module sto_vnode_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       init_i = 1'b0;
   logic       chan_i = 1'b0;
   logic [1:0] ext_i = 2'b00;
   logic [2:0] rd_addr_i = 3'd0;
   logic       out_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic  exp_q[$];
   string req_q[$];

   logic [7:0] m_mem = 8'h00;
   logic       m_agree = 1'b0;

   always #10 clk = ~clk;

   sto_vnode u_sto_vnode (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .chan_i(chan_i),
      .ext_i(ext_i), .rd_addr_i(rd_addr_i), .out_o(out_o)
   );

   task automatic step(input logic ini, input logic ch, input logic [1:0] ex,
                       input logic [2:0] ad, input string req);
      logic e;
      logic eq;
      @(negedge clk);
      init_i = ini; chan_i = ch; ext_i = ex; rd_addr_i = ad;
      eq = (ex == {ch, ch});
      if (ini)     e = 1'b0;
      else if (eq) e = ch;
      else         e = m_mem[ad];
      if (ini) begin
         m_mem   = {m_mem[6:0], ch};
         m_agree = 1'b0;
      end else begin
         if (eq && !m_agree) m_mem = {m_mem[6:0], ch};
         m_agree = eq;
      end
      exp_q.push_back(e);
      req_q.push_back(req);
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < 8; a++) step(1'b0, 1'b1, 2'b00, a[2:0], req);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            logic  e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            checks++;
            if (out_o !== e) begin
               errors++;
               $display("FAIL %s out_o=%0b expected=%0b", r, out_o, e);
            end
         end
      end
   end

   initial begin : watchdog
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      checks++;
      if (out_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 out_o=%0b expected=0", out_o);
      end
      rst_n = 1'b1;
      // R1: memory cleared by reset
      sweep("R1");
      // R6/R7: load pattern, extrinsic bits toggled to show they are ignored
      step(1'b1, 1'b1, 2'b11, 3'd0, "R7");
      step(1'b1, 1'b0, 2'b10, 3'd1, "R7");
      step(1'b1, 1'b1, 2'b01, 3'd2, "R7");
      step(1'b1, 1'b1, 2'b00, 3'd3, "R7");
      step(1'b1, 1'b0, 2'b11, 3'd4, "R7");
      step(1'b1, 1'b0, 2'b00, 3'd5, "R7");
      step(1'b1, 1'b1, 2'b10, 3'd6, "R7");
      step(1'b1, 1'b0, 2'b11, 3'd7, "R7");
      sweep("R6");
      // R2 + R4 + R8: first agreement after init stores
      step(1'b0, 1'b1, 2'b11, 3'd0, "R2");
      sweep("R4");
      // R5: stay in agreement, then flip directly
      step(1'b0, 1'b0, 2'b00, 3'd0, "R2");
      step(1'b0, 1'b0, 2'b00, 3'd0, "R2");
      step(1'b0, 1'b1, 2'b11, 3'd0, "R2");
      step(1'b0, 1'b0, 2'b00, 3'd0, "R2");
      sweep("R5");
      // R9 + R4: degenerate in between, then zeros enter
      step(1'b0, 1'b0, 2'b00, 3'd0, "R2");
      step(1'b0, 1'b0, 2'b01, 3'd3, "R9");
      step(1'b0, 1'b0, 2'b00, 3'd0, "R4");
      sweep("R3");
      // R8: agreement, init, then same agreement stores again
      step(1'b0, 1'b1, 2'b11, 3'd0, "R2");
      step(1'b1, 1'b1, 2'b11, 3'd0, "R7");
      step(1'b0, 1'b1, 2'b11, 3'd0, "R8");
      sweep("R8");
      // mixed traffic
      lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step((lfsr[15:12] == 4'h0), lfsr[0], lfsr[9] ? {lfsr[0], lfsr[0]} : lfsr[2:1],
              lfsr[6:4], "R3");
      end
      repeat (3) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule